// File: doc/BRIEF.md
# Auto-Request Block Copy DMA Channel

This block is a single DMA channel that copies a block of memory from one place to another without processor help. Software programs a source address, a destination address, a unit count and a channel control word through a small register write/read port. A separate operation half-word supplies a master enable. Once the channel enable, the master enable and the auto-request resource code are all present, the channel runs the whole block on its own bus master port. Each unit is one read from the source followed by one write to the destination.

A unit is either a byte or a 16-bit word. Each of the two addresses has its own mode: fixed, counting up or counting down. The step is one in byte mode and two in word mode. The count register counts down as units finish. When the block is done, the hardware clears the channel enable bit, so software sees completion by reading the control word. Word transfers from or to an odd address are refused: the channel stops before any bus access and raises an address-error flag.

Top module: `dma_auto_channel`

## Requirements
- R1: After reset the source, destination, count, control and operation registers all read 0, `busy` is 0 and `m_valid` is 0.
- R2: Registers sit at word offsets 0x40 (source), 0x44 (destination), 0x48 (operation half in bits 31:16, count in bits 15:0) and 0x4C (control in bits 15:0, bits 31:16 read 0). Each byte is written only when its `reg_wbe` bit is set. A read returns the value on `reg_rdata` one cycle after `reg_rd`.
- R3: The start condition is tested in the cycle after a write touches the operation half or the control half. A transfer starts only if control bit 0 (channel enable), operation bit 0 (master enable) and control bits 11:8 equal to 0xC are all set. Otherwise the channel stays idle with no bus request, and the enable bit keeps its value.
- R4: Each unit issues a read at the source address (`m_write`=0), then a write at the destination address (`m_write`=1) carrying the data just read. In byte mode (control bit 3 = 0) only `m_rdata[7:0]` is used, and `m_wdata` is that byte with bits 15:8 zero. In word mode all 16 bits are copied. `m_word` equals control bit 3.
- R5: The destination mode is in control bits 15:14 and the source mode in bits 13:12. Mode 1 adds the step after each unit, mode 2 subtracts it, and modes 0 and 3 leave the address unchanged. The step is 1 in byte mode and 2 in word mode. The address registers read back the updated values.
- R6: Exactly N units are copied when the count is N, and 65536 units when the count is 0. The count register drops by one after every unit and reads 0 when the block finishes.
- R7: When the last unit's write completes, control bit 0 is cleared by hardware and `busy` falls.
- R8: A word-mode start with an odd source or destination address makes no bus access. It clears control bit 0 and sets operation bit 2 (address error).
- R9: Register writes that arrive while `busy` is high are ignored.
- R10: While `m_valid` is high and `m_ready` is low, the request (`m_valid`, `m_addr`, `m_write`) holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | REG_AW | Register write byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_wbe | input | 4 | Byte enables for the write |
| reg_rd | input | 1 | Register read strobe |
| reg_raddr | input | REG_AW | Register read byte offset |
| reg_rdata | output | 32 | Read data, one cycle after the strobe |
| m_valid | output | 1 | Bus request valid |
| m_write | output | 1 | 1 = write, 0 = read |
| m_word | output | 1 | 1 = 16-bit access, 0 = byte |
| m_addr | output | ADDR_W | Bus address |
| m_wdata | output | 16 | Write data |
| m_rdata | input | 16 | Read data, taken when `m_ready` is high |
| m_ready | input | 1 | Bus accepts the current request |
| busy | output | 1 | High while a block is being copied |

## Verification
The bench aims at a zero count, which must run 65536 units. A design that treated zero as nothing to do would finish at once, and one that was off by one would end with a stray unit or with a nonzero count. It drives non-auto-request codes and a cleared master enable, where a wrongly started channel shows up as an unexpected bus request. It also checks that a later write to the operation half alone then starts the block. Odd word addresses must abort with no bus cycle and raise the flag. Random back-pressure on `m_ready` exposes a request that moves before it is accepted, and a mid-block write to the addresses or the control word exposes a channel that is not locked while busy.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam logic [15:0] OFS_SRC = 16'h0040;
  localparam logic [15:0] OFS_DST = 16'h0044;
  localparam logic [15:0] OFS_CNT = 16'h0048;
  localparam logic [15:0] OFS_CTL = 16'h004C;
  localparam logic [3:0]  RS_AUTO = 4'hC;
  localparam int          OP_AERR = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} dma_state_t;

  function automatic logic [15:0] merge16(input logic [15:0] old_v,
                                          input logic [15:0] new_v,
                                          input logic [1:0]  be);
    merge16 = {be[1] ? new_v[15:8] : old_v[15:8],
               be[0] ? new_v[7:0]  : old_v[7:0]};
  endfunction

  function automatic logic [31:0] merge32(input logic [31:0] old_v,
                                          input logic [31:0] new_v,
                                          input logic [3:0]  be);
    merge32 = {merge16(old_v[31:16], new_v[31:16], be[3:2]),
               merge16(old_v[15:0],  new_v[15:0],  be[1:0])};
  endfunction
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [1:0]        mode,
  input  logic              word,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] step;
  assign step = word ? ADDR_W'(2) : ADDR_W'(1);

  always_comb begin
    case (mode)
      2'd1:    nxt = cur + step;
      2'd2:    nxt = cur - step;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [REG_AW-1:0] waddr,
  input  logic [31:0]       wdata,
  input  logic [3:0]        wbe,
  input  logic              rd,
  input  logic [REG_AW-1:0] raddr,
  output logic [31:0]       rdata,
  input  logic              busy,
  input  logic              unit_done,
  input  logic              finish,
  input  logic              abort,
  input  logic [ADDR_W-1:0] src_nxt,
  input  logic [ADDR_W-1:0] dst_nxt,
  output logic [ADDR_W-1:0] sar,
  output logic [ADDR_W-1:0] dar,
  output logic [15:0]       tcr,
  output logic [15:0]       chcr,
  output logic [15:0]       opr,
  output logic              chk
);
  logic sw_ok, hit_src, hit_dst, hit_cnt, hit_ctl;
  assign sw_ok   = wr && !busy;
  assign hit_src = (waddr == REG_AW'(OFS_SRC));
  assign hit_dst = (waddr == REG_AW'(OFS_DST));
  assign hit_cnt = (waddr == REG_AW'(OFS_CNT));
  assign hit_ctl = (waddr == REG_AW'(OFS_CTL));

  always_ff @(posedge clk) begin
    if (rst) begin
      sar  <= '0;
      dar  <= '0;
      tcr  <= '0;
      chcr <= '0;
      opr  <= '0;
      chk  <= 1'b0;
    end else begin
      chk <= sw_ok && ((hit_cnt && (wbe[3:2] != 2'b00)) ||
                       (hit_ctl && (wbe[1:0] != 2'b00)));
      if (sw_ok && hit_src) sar <= ADDR_W'(merge32(32'(sar), wdata, wbe));
      if (sw_ok && hit_dst) dar <= ADDR_W'(merge32(32'(dar), wdata, wbe));
      if (sw_ok && hit_cnt) begin
        opr <= merge16(opr, wdata[31:16], wbe[3:2]);
        tcr <= merge16(tcr, wdata[15:0],  wbe[1:0]);
      end
      if (sw_ok && hit_ctl) chcr <= merge16(chcr, wdata[15:0], wbe[1:0]);
      if (unit_done) begin
        sar <= src_nxt;
        dar <= dst_nxt;
        tcr <= tcr - 16'd1;
      end
      if (finish) chcr[0] <= 1'b0;
      if (abort) begin
        chcr[0]       <= 1'b0;
        opr[OP_AERR]  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      if (raddr == REG_AW'(OFS_SRC))      rdata <= 32'(sar);
      else if (raddr == REG_AW'(OFS_DST)) rdata <= 32'(dar);
      else if (raddr == REG_AW'(OFS_CNT)) rdata <= {opr, tcr};
      else if (raddr == REG_AW'(OFS_CTL)) rdata <= {16'h0000, chcr};
      else                                rdata <= '0;
    end
  end

  AST_FINISH_CLEARS_EN: assert property (@(posedge clk) disable iff (rst)
    finish |=> !chcr[0]); // R7
  AST_ABORT_RAISES_FLAG: assert property (@(posedge clk) disable iff (rst)
    abort |=> opr[OP_AERR] && !chcr[0]); // R8
  AST_COUNT_STEPS_DOWN: assert property (@(posedge clk) disable iff (rst)
    unit_done |=> tcr == $past(tcr) - 16'd1); // R6
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    busy && wr && hit_src && !unit_done |=> sar == $past(sar)); // R9
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chk,
  input  logic              ch_en,
  input  logic              master_en,
  input  logic [3:0]        rs,
  input  logic              word,
  input  logic [ADDR_W-1:0] sar,
  input  logic [ADDR_W-1:0] dar,
  input  logic [15:0]       tcr,
  output logic              m_valid,
  output logic              m_write,
  output logic              m_word,
  output logic [ADDR_W-1:0] m_addr,
  output logic [15:0]       m_wdata,
  input  logic [15:0]       m_rdata,
  input  logic              m_ready,
  output logic              busy,
  output logic              unit_done,
  output logic              finish,
  output logic              abort
);
  dma_state_t state;
  logic [15:0] hold;
  logic go, misaligned;

  assign go         = chk && ch_en && master_en && (rs == RS_AUTO);
  assign misaligned = word && (sar[0] || dar[0]);
  assign abort      = (state == ST_IDLE) && go && misaligned;
  assign unit_done  = (state == ST_WR) && m_ready;
  assign finish     = unit_done && (tcr == 16'd1);

  assign busy    = (state != ST_IDLE);
  assign m_valid = busy;
  assign m_write = (state == ST_WR);
  assign m_word  = word;
  assign m_addr  = (state == ST_WR) ? dar : sar;
  assign m_wdata = hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      hold  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (go && !misaligned) state <= ST_RD;
        ST_RD: if (m_ready) begin
          hold  <= word ? m_rdata : {8'h00, m_rdata[7:0]};
          state <= ST_WR;
        end
        ST_WR: if (m_ready) state <= finish ? ST_IDLE : ST_RD;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_write)); // R10
  AST_START_NEEDS_AUTO: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(rs) == RS_AUTO && $past(ch_en) && $past(master_en)); // R3
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
    m_valid && !m_write && m_ready |=> m_valid && m_write); // R4
  AST_WORD_EVEN: assert property (@(posedge clk) disable iff (rst)
    m_valid && m_word |-> !m_addr[0]); // R8
endmodule

// File: rtl/dma_auto_channel.sv
module dma_auto_channel #(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_waddr,
  input  logic [31:0]       reg_wdata,
  input  logic [3:0]        reg_wbe,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_raddr,
  output logic [31:0]       reg_rdata,
  output logic              m_valid,
  output logic              m_write,
  output logic              m_word,
  output logic [ADDR_W-1:0] m_addr,
  output logic [15:0]       m_wdata,
  input  logic [15:0]       m_rdata,
  input  logic              m_ready,
  output logic              busy
);
  logic [ADDR_W-1:0] sar, dar, src_nxt, dst_nxt;
  logic [15:0] tcr, chcr, opr;
  logic chk, unit_done, finish, abort;

  dma_chan_regs #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst(rst),
    .wr(reg_wr), .waddr(reg_waddr), .wdata(reg_wdata), .wbe(reg_wbe),
    .rd(reg_rd), .raddr(reg_raddr), .rdata(reg_rdata),
    .busy(busy), .unit_done(unit_done), .finish(finish), .abort(abort),
    .src_nxt(src_nxt), .dst_nxt(dst_nxt),
    .sar(sar), .dar(dar), .tcr(tcr), .chcr(chcr), .opr(opr), .chk(chk)
  );

  dma_addr_step #(.ADDR_W(ADDR_W)) u_src_step (
    .cur(sar), .mode(chcr[13:12]), .word(chcr[3]), .nxt(src_nxt)
  );

  dma_addr_step #(.ADDR_W(ADDR_W)) u_dst_step (
    .cur(dar), .mode(chcr[15:14]), .word(chcr[3]), .nxt(dst_nxt)
  );

  dma_chan_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk(clk), .rst(rst), .chk(chk),
    .ch_en(chcr[0]), .master_en(opr[0]), .rs(chcr[11:8]), .word(chcr[3]),
    .sar(sar), .dar(dar), .tcr(tcr),
    .m_valid(m_valid), .m_write(m_write), .m_word(m_word), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready),
    .busy(busy), .unit_done(unit_done), .finish(finish), .abort(abort)
  );
endmodule

// File: tb/test_dma_auto_channel.sv
module test_dma_auto_channel;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int REG_AW = 8;
  localparam int WATCHDOG = 195000;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [REG_AW-1:0] reg_waddr = '0, reg_raddr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [3:0]  reg_wbe = '0;
  logic m_valid, m_write, m_word, busy;
  logic [ADDR_W-1:0] m_addr;
  logic [15:0] m_wdata, m_rdata = '0;
  logic m_ready = 1'b0;

  dma_auto_channel #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) i_dma_auto_channel (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_wbe(reg_wbe), .reg_rd(reg_rd),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .m_valid(m_valid),
    .m_write(m_write), .m_word(m_word), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_ready(m_ready), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check_eq(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Bench memory and reference model
  logic [7:0] mem [logic [31:0]];
  function automatic logic [7:0] rdbyte(logic [31:0] a);
    return mem.exists(a) ? mem[a] : (a[7:0] ^ 8'hA5);
  endfunction

  bit m_act = 0, e_phase = 0, e_word = 0, always_ready = 0;
  logic [31:0] e_src, e_dst;
  logic [1:0] e_sm, e_dm;
  logic [15:0] e_data;
  int e_left = 0, e_units = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit pend = 0;
  logic [31:0] prev_addr;
  logic prev_wr;

  function automatic logic [31:0] stepped(logic [31:0] a, logic [1:0] md, bit w);
    int st = w ? 2 : 1;
    if (md == 2'd1) return a + st;
    if (md == 2'd2) return a - st;
    return a;
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      m_ready = 1'b0;
      pend = 0;
    end else begin
      if (pend) begin
        checks++;
        if (!(m_valid && m_addr == prev_addr && m_write == prev_wr)) begin
          errors++;
          $display("FAIL R10 request moved before ready actual=%h/%b expected=%h/%b",
                   m_addr, m_write, prev_addr, prev_wr);
        end
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m_ready = always_ready ? 1'b1 : lfsr[0];
      m_rdata = m_word ? {rdbyte(m_addr + 1), rdbyte(m_addr)} : {8'hEE, rdbyte(m_addr)};
      if (m_valid && m_ready) begin
        if (!m_act) begin
          check_eq("R3", "unexpected bus request addr", m_addr, 32'hFFFF_FFFF);
        end else if (!e_phase) begin
          check_eq("R4", "read request {write,word}", {30'd0, m_write, m_word}, {30'd0, 1'b0, e_word});
          check_eq("R5", "read address", m_addr, e_src);
          e_data = e_word ? m_rdata : {8'h00, m_rdata[7:0]};
          e_phase = 1;
        end else begin
          check_eq("R4", "write request {write,word}", {30'd0, m_write, m_word}, {30'd0, 1'b1, e_word});
          check_eq("R5", "write address", m_addr, e_dst);
          check_eq("R4", "write data", {16'd0, m_wdata}, {16'd0, e_data});
          mem[m_addr] = m_wdata[7:0];
          if (m_word) mem[m_addr + 1] = m_wdata[15:8];
          e_src = stepped(e_src, e_sm, e_word);
          e_dst = stepped(e_dst, e_dm, e_word);
          e_units++;
          e_left--;
          if (e_left == 0) m_act = 0;
          e_phase = 0;
        end
      end
      pend = m_valid && !m_ready;
      prev_addr = m_addr;
      prev_wr = m_write;
    end
  end

  task automatic reg_write(logic [7:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d; reg_wbe = be;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_raddr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic arm(logic [31:0] s, logic [31:0] d, int n, logic [1:0] sm, logic [1:0] dm, bit w);
    e_src = s; e_dst = d; e_left = n; e_sm = sm; e_dm = dm; e_word = w;
    e_units = 0; e_phase = 0; m_act = 1;
  endtask

  function automatic logic [31:0] ctl(logic [1:0] dm, logic [1:0] sm, logic [3:0] rs, bit w, bit en);
    return {16'h0000, dm, sm, rs, 4'h0, w, 2'b00, en};
  endfunction

  task automatic start(logic [31:0] s, logic [31:0] d, logic [15:0] n,
                       logic [1:0] sm, logic [1:0] dm, bit w);
    reg_write(8'h40, s, 4'hF);
    reg_write(8'h44, d, 4'hF);
    reg_write(8'h48, {16'h0001, n}, 4'hF);
    arm(s, d, (n == 0) ? 65536 : int'(n), sm, dm, w);
    reg_write(8'h4C, ctl(dm, sm, 4'hC, w, 1'b1), 4'h3);
  endtask

  task automatic finish_check(string tag, int n);
    logic [31:0] r;
    wait_idle();
    check_eq("R6", {tag, " units copied"}, e_units, n);
    check_eq("R7", {tag, " busy low at end"}, {31'd0, busy}, 0);
    reg_read(8'h4C, r);
    check_eq("R7", {tag, " enable cleared"}, {31'd0, r[0]}, 0);
    reg_read(8'h48, r);
    check_eq("R6", {tag, " count reads zero"}, {16'd0, r[15:0]}, 0);
    reg_read(8'h40, r);
    check_eq("R5", {tag, " final source"}, r, e_src);
    reg_read(8'h44, r);
    check_eq("R5", {tag, " final destination"}, r, e_dst);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check_eq("R1", "busy after reset", {31'd0, busy}, 0);
    check_eq("R1", "m_valid after reset", {31'd0, m_valid}, 0);
    for (int k = 0; k < 4; k++) begin
      reg_read(8'h40 + 8'(4 * k), r);
      check_eq("R1", "register after reset", r, 0);
    end

    // R2 byte enables and layout
    reg_write(8'h40, 32'h1122_3344, 4'b0101);
    reg_read(8'h40, r);
    check_eq("R2", "source partial write", r, 32'h0022_0044);
    reg_write(8'h48, 32'hABCD_1234, 4'b0011);
    reg_read(8'h48, r);
    check_eq("R2", "count half only", r, 32'h0000_1234);
    reg_write(8'h4C, 32'hFFFF_0230, 4'b1110);
    reg_read(8'h4C, r);
    check_eq("R2", "control upper reads zero", r, 32'h0000_0200);

    // R4 R5 R6 R7 byte copy, both addresses counting up
    start(32'h1000, 32'h1800, 16'd5, 2'd1, 2'd1, 1'b0);
    finish_check("byte up", 5);
    for (int k = 0; k < 5; k++)
      check_eq("R4", "copied byte", {24'd0, rdbyte(32'h1800 + k)}, {24'd0, rdbyte(32'h1000 + k)});

    // R5 word copy, source down, destination fixed (mode 0)
    start(32'h3010, 32'h4000, 16'd3, 2'd2, 2'd0, 1'b1);
    finish_check("word down", 3);
    check_eq("R5", "word source end", e_src, 32'h300A);

    // R9 writes during busy are ignored
    start(32'h7000, 32'h7100, 16'd6, 2'd1, 2'd2, 1'b0);
    repeat (2) @(negedge clk);
    reg_write(8'h40, 32'hDEAD_0000, 4'hF);
    reg_write(8'h4C, 32'h0, 4'h3);
    finish_check("busy writes R9", 6);

    // R3 non-auto resource code leaves the channel idle
    reg_write(8'h40, 32'h2000, 4'hF);
    reg_write(8'h44, 32'h2100, 4'hF);
    reg_write(8'h48, {16'h0001, 16'd2}, 4'hF);
    reg_write(8'h4C, ctl(2'd1, 2'd1, 4'h3, 1'b0, 1'b1), 4'h3);
    repeat (20) @(negedge clk);
    check_eq("R3", "busy with code 3", {31'd0, busy}, 0);
    reg_read(8'h4C, r);
    check_eq("R3", "enable kept with code 3", {31'd0, r[0]}, 1);

    // R3 master enable off, then a write to the operation half starts
    reg_write(8'h48, 32'h0, 4'b1100);
    reg_write(8'h4C, ctl(2'd1, 2'd1, 4'hC, 1'b0, 1'b1), 4'h3);
    repeat (20) @(negedge clk);
    check_eq("R3", "busy without master enable", {31'd0, busy}, 0);
    arm(32'h2000, 32'h2100, 2, 2'd1, 2'd1, 1'b0);
    reg_write(8'h48, 32'h0001_0000, 4'b1100);
    finish_check("R3 late master enable", 2);

    // R8 misaligned word start
    reg_write(8'h40, 32'h2001, 4'hF);
    reg_write(8'h44, 32'h2200, 4'hF);
    reg_write(8'h48, {16'h0001, 16'd4}, 4'hF);
    reg_write(8'h4C, ctl(2'd1, 2'd1, 4'hC, 1'b1, 1'b1), 4'h3);
    repeat (10) @(negedge clk);
    check_eq("R8", "busy on odd word", {31'd0, busy}, 0);
    reg_read(8'h4C, r);
    check_eq("R8", "enable cleared on odd word", {31'd0, r[0]}, 0);
    reg_read(8'h48, r);
    check_eq("R8", "address error flag", {16'd0, r[31:16]}, 32'h0005);
    reg_write(8'h48, 32'h0001_0000, 4'b1100);

    // R6 zero count copies 65536 units (modes 0 and 3 keep addresses)
    always_ready = 1;
    start(32'h5000, 32'h6000, 16'd0, 2'd0, 2'd3, 1'b0);
    finish_check("zero count", 65536);
    always_ready = 0;

    summary();
  end
endmodule